// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Unit

This block produces the port-to-port doorbell interrupts for a shared dual-port memory. Two reserved words at the top of the address space act as mailboxes: the very last word belongs to the right port and the word just below it belongs to the left port. When one port stores a word into the other port's mailbox, the owner of that mailbox gets an interrupt. The owner acknowledges it by reading its own mailbox. The message words themselves live in the ordinary memory array, outside this block. Their meaning is left to the software on each side.

The unit watches each port's access strobes every clock: select, write/read, address, and the contention busy flag from the arbiter. A port that has lost arbitration (busy high) can neither raise the peer's interrupt nor clear its own. Each interrupt is a registered, active-low output. A set and a clear arriving in the same cycle resolve in favour of the set, so that a fresh message is never dropped.

Top module: `mbx_irq_unit`

## Requirements
- R1: While `rst` is high, both `lt_irq_n` and `rt_irq_n` are driven high (deasserted) from the next clock edge on.
- R2: The right mailbox address is all ones (0x3FFF for AW=14) and the left mailbox address is all ones minus one (0x3FFE). An access to any other address changes neither interrupt.
- R3: A write accepted from one port into the other port's mailbox (sel=1, wr=1, busy=0) drives the owner's interrupt low one clock edge later.
- R4: A read accepted from the owner of a mailbox (sel=1, wr=0, busy=0) drives that owner's interrupt high one clock edge later, unless R8 applies.
- R5: A port reading the other port's mailbox leaves that other port's interrupt unchanged.
- R6: A write into the peer's mailbox made while the writer's busy is high does not set the peer's interrupt.
- R7: A read of its own mailbox made while the reader's busy is high does not clear the reader's interrupt.
- R8: When a set and a clear of the same interrupt occur in the same cycle, the interrupt ends up set (low).
- R9: A port writing its own mailbox changes neither interrupt.
- R10: With `sel` low, a port's `wr`, `addr` and `busy` have no effect on either interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lt_sel | input | 1 | Left port access strobe for this cycle |
| lt_wr | input | 1 | Left port direction, 1 = write, 0 = read |
| lt_addr | input | AW | Left port word address |
| lt_busy | input | 1 | Left port lost contention arbitration |
| rt_sel | input | 1 | Right port access strobe for this cycle |
| rt_wr | input | 1 | Right port direction, 1 = write, 0 = read |
| rt_addr | input | AW | Right port word address |
| rt_busy | input | 1 | Right port lost contention arbitration |
| lt_irq_n | output | 1 | Left port interrupt, active low |
| rt_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The main function is driven with writes and reads that cover every pairing of port and address class: own mailbox, peer mailbox, a neighbouring ordinary address, and address zero. These separate a correct mailbox decode from a swapped one or an off-by-one decode. Each set and each clear is repeated with busy high, which shows that the arbitration gate is applied to the acting port and not to the other one. Both ports also act in the same cycle: a set racing a clear on the same interrupt exposes the priority, and independent sets on both sides show that the two sides do not interfere.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Which side of the dual-port memory a piece of logic serves.
    typedef enum logic {
        SIDE_LT = 1'b0,
        SIDE_RT = 1'b1
    } side_e;

    // Accepted mailbox events produced by one port's decoder.
    typedef struct packed {
        logic post;   // write landed in the peer's mailbox
        logic fetch;  // read of this port's own mailbox
    } mbx_evt_t;

    // Next-state action on one interrupt flag.
    typedef enum logic [1:0] {
        IRQ_HOLD = 2'd0,
        IRQ_SET  = 2'd1,
        IRQ_CLR  = 2'd2
    } irq_op_e;

    // Bit 0 of a side's mailbox address; every upper bit is one.
    function automatic logic mbox_lsb(input side_e s);
        return (s == SIDE_RT) ? 1'b1 : 1'b0;
    endfunction

    function automatic side_e peer_of(input side_e s);
        return (s == SIDE_RT) ? SIDE_LT : SIDE_RT;
    endfunction

    // A set wins over a simultaneous clear so a new message is kept.
    function automatic irq_op_e resolve_op(input logic set_req, input logic clr_req);
        if (set_req)      return IRQ_SET;
        else if (clr_req) return IRQ_CLR;
        else              return IRQ_HOLD;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int    AW   = 14,
    parameter side_e SIDE = SIDE_LT
) (
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic          busy,
    output mbx_evt_t      evt
);
    localparam logic [AW-1:0] OWN_ADDR  = {{(AW-1){1'b1}}, mbox_lsb(SIDE)};
    localparam logic [AW-1:0] PEER_ADDR = {{(AW-1){1'b1}}, mbox_lsb(peer_of(SIDE))};

    logic granted;
    logic own_hit;
    logic peer_hit;

    always_comb begin
        granted   = sel & ~busy;
        own_hit   = (addr == OWN_ADDR);
        peer_hit  = (addr == PEER_ADDR);
        evt.post  = granted &  wr & peer_hit;
        evt.fetch = granted & ~wr & own_hit;
    end
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);
    irq_op_e op;

    always_comb op = resolve_op(set_req, clr_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_n <= 1'b1;
        end else begin
            unique case (op)
                IRQ_SET: irq_n <= 1'b0;
                IRQ_CLR: irq_n <= 1'b1;
                default: irq_n <= irq_n;
            endcase
        end
    end
endmodule

// File: rtl/mbx_irq_unit.sv
module mbx_irq_unit
    import mbx_pkg::*;
#(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lt_sel,
    input  logic          lt_wr,
    input  logic [AW-1:0] lt_addr,
    input  logic          lt_busy,
    input  logic          rt_sel,
    input  logic          rt_wr,
    input  logic [AW-1:0] rt_addr,
    input  logic          rt_busy,
    output logic          lt_irq_n,
    output logic          rt_irq_n
);
    localparam int NSIDE = 2;

    logic [NSIDE-1:0]          p_sel;
    logic [NSIDE-1:0]          p_wr;
    logic [NSIDE-1:0][AW-1:0]  p_addr;
    logic [NSIDE-1:0]          p_busy;
    mbx_evt_t [NSIDE-1:0]      p_evt;
    logic [NSIDE-1:0]          p_irq_n;

    always_comb begin
        p_sel [SIDE_LT] = lt_sel;   p_sel [SIDE_RT] = rt_sel;
        p_wr  [SIDE_LT] = lt_wr;    p_wr  [SIDE_RT] = rt_wr;
        p_addr[SIDE_LT] = lt_addr;  p_addr[SIDE_RT] = rt_addr;
        p_busy[SIDE_LT] = lt_busy;  p_busy[SIDE_RT] = rt_busy;
    end

    for (genvar i = 0; i < NSIDE; i++) begin : g_side
        localparam side_e ME   = side_e'(i);
        localparam int    PEER = int'(peer_of(ME));

        mbx_port_decode #(.AW(AW), .SIDE(ME)) u_dec (
            .sel  (p_sel[i]),
            .wr   (p_wr[i]),
            .addr (p_addr[i]),
            .busy (p_busy[i]),
            .evt  (p_evt[i])
        );

        // This side's interrupt is raised by the peer's post and
        // dropped by this side's own fetch.
        mbx_irq_flag u_flag (
            .clk     (clk),
            .rst     (rst),
            .set_req (p_evt[PEER].post),
            .clr_req (p_evt[i].fetch),
            .irq_n   (p_irq_n[i])
        );
    end

    assign lt_irq_n = p_irq_n[SIDE_LT];
    assign rt_irq_n = p_irq_n[SIDE_RT];
endmodule

// File: rtl/mbx_irq_unit_chk.sv
module mbx_irq_unit_chk #(
    parameter int AW = 14
) (
    input logic          clk,
    input logic          rst,
    input logic          lt_sel,
    input logic          lt_wr,
    input logic [AW-1:0] lt_addr,
    input logic          lt_busy,
    input logic          rt_sel,
    input logic          rt_wr,
    input logic [AW-1:0] rt_addr,
    input logic          rt_busy,
    input logic          lt_irq_n,
    input logic          rt_irq_n
);
    localparam logic [AW-1:0] RT_BOX = {AW{1'b1}};
    localparam logic [AW-1:0] LT_BOX = {{(AW-1){1'b1}}, 1'b0};

    logic lt_to_rt, rt_to_lt, lt_own_rd, rt_own_rd;
    assign lt_to_rt  = lt_sel &  lt_wr & (lt_addr == RT_BOX);
    assign rt_to_lt  = rt_sel &  rt_wr & (rt_addr == LT_BOX);
    assign lt_own_rd = lt_sel & ~lt_wr & (lt_addr == LT_BOX);
    assign rt_own_rd = rt_sel & ~rt_wr & (rt_addr == RT_BOX);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (lt_irq_n && rt_irq_n));

    a_r3_set_right: assert property (@(posedge clk) disable iff (rst)
        (lt_to_rt && !lt_busy) |=> !rt_irq_n);

    a_r3_set_left: assert property (@(posedge clk) disable iff (rst)
        (rt_to_lt && !rt_busy) |=> !lt_irq_n);

    a_r4_clear_right: assert property (@(posedge clk) disable iff (rst)
        (rt_own_rd && !rt_busy && !(lt_to_rt && !lt_busy)) |=> rt_irq_n);

    a_r4_clear_left: assert property (@(posedge clk) disable iff (rst)
        (lt_own_rd && !lt_busy && !(rt_to_lt && !rt_busy)) |=> lt_irq_n);

    // R5, R7, R9, R10: without an accepted owner read, a low interrupt stays low.
    a_r5_hold_right: assert property (@(posedge clk) disable iff (rst)
        (!rt_irq_n && !(rt_own_rd && !rt_busy)) |=> !rt_irq_n);

    a_r5_hold_left: assert property (@(posedge clk) disable iff (rst)
        (!lt_irq_n && !(lt_own_rd && !lt_busy)) |=> !lt_irq_n);

    // R6, R2, R9, R10: without an accepted peer post, a high interrupt stays high.
    a_r6_no_set_right: assert property (@(posedge clk) disable iff (rst)
        (rt_irq_n && !(lt_to_rt && !lt_busy)) |=> rt_irq_n);

    a_r6_no_set_left: assert property (@(posedge clk) disable iff (rst)
        (lt_irq_n && !(rt_to_lt && !rt_busy)) |=> lt_irq_n);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (lt_to_rt && !lt_busy && rt_own_rd && !rt_busy) |=> !rt_irq_n);
endmodule

bind mbx_irq_unit mbx_irq_unit_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst),
    .lt_sel(lt_sel), .lt_wr(lt_wr), .lt_addr(lt_addr), .lt_busy(lt_busy),
    .rt_sel(rt_sel), .rt_wr(rt_wr), .rt_addr(rt_addr), .rt_busy(rt_busy),
    .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
);

// File: tb/mbx_irq_unit_test.sv
module mbx_irq_unit_test;
    localparam int AW = 14;
    localparam logic [AW-1:0] RBOX = 14'h3FFF;
    localparam logic [AW-1:0] LBOX = 14'h3FFE;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lt_sel = 0, lt_wr = 0, lt_busy = 0;
    logic          rt_sel = 0, rt_wr = 0, rt_busy = 0;
    logic [AW-1:0] lt_addr = '0, rt_addr = '0;
    logic          lt_irq_n, rt_irq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    mbx_irq_unit #(.AW(AW)) uut (.*);

    typedef struct packed {
        logic          ls; logic lw; logic [AW-1:0] la; logic lb;
        logic          rs; logic rw; logic [AW-1:0] ra; logic rb;
        logic          el; logic er;   // expected lt_irq_n, rt_irq_n after the edge
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,14'h0000,1'b0, 1'b0,1'b0,14'h0000,1'b0, 1'b1,1'b1, 4'd1},  // idle
        '{1'b1,1'b1,RBOX,    1'b0, 1'b0,1'b0,14'h0000,1'b0, 1'b1,1'b0, 4'd3},  // L posts R
        '{1'b0,1'b0,14'h0000,1'b0, 1'b1,1'b0,LBOX,    1'b0, 1'b1,1'b0, 4'd5},  // R reads L box
        '{1'b1,1'b0,RBOX,    1'b0, 1'b0,1'b0,14'h0000,1'b0, 1'b1,1'b0, 4'd5},  // L reads R box
        '{1'b0,1'b0,14'h0000,1'b0, 1'b1,1'b0,RBOX,    1'b1, 1'b1,1'b0, 4'd7},  // R own read, busy
        '{1'b0,1'b0,14'h0000,1'b0, 1'b1,1'b0,RBOX,    1'b0, 1'b1,1'b1, 4'd4},  // R own read
        '{1'b0,1'b0,14'h0000,1'b0, 1'b1,1'b1,LBOX,    1'b1, 1'b1,1'b1, 4'd6},  // R posts L, busy
        '{1'b0,1'b0,14'h0000,1'b0, 1'b1,1'b1,LBOX,    1'b0, 1'b0,1'b1, 4'd3},  // R posts L
        '{1'b1,1'b1,LBOX,    1'b0, 1'b0,1'b0,14'h0000,1'b0, 1'b0,1'b1, 4'd9},  // L writes own
        '{1'b0,1'b0,14'h0000,1'b0, 1'b1,1'b1,RBOX,    1'b0, 1'b0,1'b1, 4'd9},  // R writes own
        '{1'b1,1'b1,14'h3FFD,1'b0, 1'b0,1'b0,14'h0000,1'b0, 1'b0,1'b1, 4'd2},  // L writes neighbour
        '{1'b1,1'b0,14'h0000,1'b0, 1'b1,1'b1,14'h3FFD,1'b0, 1'b0,1'b1, 4'd2},  // other addresses
        '{1'b0,1'b0,LBOX,    1'b0, 1'b0,1'b1,RBOX,    1'b0, 1'b0,1'b1, 4'd10}, // L read own, no sel
        '{1'b1,1'b0,LBOX,    1'b0, 1'b1,1'b1,LBOX,    1'b0, 1'b0,1'b1, 4'd8},  // set vs clear L
        '{1'b1,1'b0,LBOX,    1'b0, 1'b0,1'b0,14'h0000,1'b0, 1'b1,1'b1, 4'd4},  // L own read
        '{1'b1,1'b1,RBOX,    1'b0, 1'b1,1'b1,LBOX,    1'b0, 1'b0,1'b0, 4'd3},  // both post
        '{1'b1,1'b0,LBOX,    1'b0, 1'b1,1'b0,RBOX,    1'b0, 1'b1,1'b1, 4'd4}   // both clear
    };

    task automatic check(input string tag, input logic el, input logic er);
        checks++;
        if (lt_irq_n !== el || rt_irq_n !== er) begin
            errors++;
            $display("FAIL %s: lt_irq_n=%b rt_irq_n=%b expected %b %b",
                     tag, lt_irq_n, rt_irq_n, el, er);
        end
    endtask

    task automatic drive(input logic ls, input logic lw, input logic [AW-1:0] la, input logic lb,
                         input logic rs, input logic rw, input logic [AW-1:0] ra, input logic rb);
        lt_sel = ls; lt_wr = lw; lt_addr = la; lt_busy = lb;
        rt_sel = rs; rt_wr = rw; rt_addr = ra; rt_busy = rb;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 1'b1, 1'b1);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].ls, VECS[i].lw, VECS[i].la, VECS[i].lb,
                  VECS[i].rs, VECS[i].rw, VECS[i].ra, VECS[i].rb);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].el, VECS[i].er);
        end

        // R8 on the right side: left posts while right reads its own box
        drive(1, 1, RBOX, 0, 1, 0, RBOX, 0);
        check("R8 right set beats clear", 1'b1, 1'b0);

        // R10: busy and write toggled with select low leave state alone
        drive(0, 0, 14'h0, 1, 0, 0, RBOX, 0);
        check("R10 no select", 1'b1, 1'b0);

        // R1: reset while interrupts pending
        drive(0, 0, 14'h0, 0, 1, 1, LBOX, 0);
        check("R3 left pending", 1'b0, 1'b0);
        rst = 1'b1;
        drive(0, 0, 14'h0, 0, 0, 0, 14'h0, 0);
        check("R1 reset clears pending", 1'b1, 1'b1);
        rst = 1'b0;
        drive(0, 0, 14'h0, 0, 0, 0, 14'h0, 0);
        check("R1 idle after reset", 1'b1, 1'b1);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule